// File: doc/BRIEF.md
# Trigger Event Packet Builder

This block turns one trigger into one stream of 32-bit words for a front-end readout card. A single-cycle `start` pulse, accepted only while the block is idle, captures the trigger time, the trigger tag, the packet ID, the output mode and two 16-channel masks. One mask marks the channels that carry a fit result; the other marks the channels whose raw samples are to be shipped. The block then sends six header words. After them come one packed result word per hit channel, then the raw samples of each selected channel, and finally a CRC32 word. Each output word leaves through a valid/ready handshake.

Fit results and raw samples are not stored in the block. They are read through two combinational lookup ports. The builder presents a channel number (and, for raw data, a sample index), and the surrounding buffer returns the data in the same cycle. The block is therefore a small control engine with five named states:

- `ST_IDLE`: waiting for `start`.
- `ST_HEAD`: six header words.
- `ST_RES`: result words.
- `ST_RAW`: raw sample words.
- `ST_CRC`: the check word.

The transitions are:

- `ST_IDLE`→`ST_HEAD` on an accepted start.
- `ST_HEAD`→`ST_RES`, `ST_RAW` or `ST_CRC` when header word 5 is taken. The target is the first section that is not empty.
- `ST_RES`→`ST_RAW` or `ST_CRC` when the last hit channel's word is taken.
- `ST_RAW`→`ST_CRC` when the final sample of the last raw channel is taken.
- `ST_CRC`→`ST_IDLE` when the CRC word is taken.

Top module: `evt_pkt_builder`

## Requirements
- R1: After reset, `out_valid` and `busy` are low.
- R2: The first word after an accepted start is 0x5AA5FF00, and it is valid in the cycle after the start edge.
- R3: Word 1 is {packet ID [31:24], type 16 [23:16], length [15:0]}. The length is the index of the last word before the CRC, equal to 5 + hits + 60 × raw channels.
- R4: Word 2 is zero. Word 3 holds the raw-channel count in [28:24], the value 60 in [22:16], the hit count in [12:8] and the trigger time in [7:0]. All other bits are zero.
- R5: Word 4 is {effective hit mask [31:16], trigger tag [15:0]}. Word 5 is {effective raw mask [31:16], 16'h0}.
- R6: Each hit channel gives one word {quality [31:30], time [29:18], amplitude [17:0]}. These words come in ascending channel order, right after word 5.
- R7: After the results, each raw channel in ascending order gives 60 words. Sample index 0..59 is in bits [17:0], and bits [31:18] are zero.
- R8: The mode value selects the sections. Mode 0 gives results only, and the raw mask counts as zero. Mode 1 gives raw only, and the hit mask counts as zero. Modes 2 and 3 give both. The total packet length is length + 2 words.
- R9: The last word is the CRC32 of all earlier words. It uses the reflected polynomial 0xEDB88320 with start value 0xFFFFFFFF. Each word is fed bit 0 first, and the result is inverted. `out_last` is high only on this word, and `out_valid` drops after it is taken.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: A start pulse while `busy` is high has no effect. The current packet is unchanged, and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| mode | input | 2 | Section select: 0 results, 1 raw, 2/3 both |
| pkt_id | input | 8 | Packet identifier |
| trig_time | input | 8 | Trigger time, 0..143 |
| trig_tag | input | 16 | Trigger tag |
| hit_mask | input | 16 | Channels with a fit result |
| raw_mask | input | 16 | Channels with raw samples |
| res_ch | output | 4 | Channel whose result is requested |
| res_qual | input | 2 | Quality flags of `res_ch` |
| res_time | input | 12 | Fitted time of `res_ch` |
| res_amp | input | 18 | Fitted amplitude of `res_ch` |
| smp_ch | output | 4 | Channel of the requested raw sample |
| smp_idx | output | 6 | Index of the requested raw sample |
| smp_data | input | 18 | Requested raw sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the CRC word |
| busy | output | 1 | A packet is in progress |

## Verification
The hardest conditions to reach are back-pressure landing on a section boundary and a start pulse that arrives during a packet. A stall during the switch from header to results, from results to raw data, or into the CRC word must not advance the channel walkers or the CRC accumulator. The stimulus holds `out_ready` low at random in about one cycle of four over long raw sections, so stalls fall on every kind of boundary. Some packets inject a second start with different masks a few words into the stream. The bench then checks that the packet is unchanged and that the bus stays quiet afterwards. Directed packets add the empty case (length 5), the full case (length 981), and each mode run with masks that that mode must suppress.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_RES,
        ST_RAW,
        ST_CRC
    } pkt_state_e;

    localparam logic [31:0] PKT_MAGIC    = 32'h5AA5_FF00;
    localparam logic [7:0]  PKT_TYPE_TRG = 8'd16;
    localparam logic [31:0] CRC_POLY_R   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT     = 32'hFFFF_FFFF;
    localparam logic [1:0]  MODE_RES     = 2'd0;
    localparam logic [1:0]  MODE_RAW     = 2'd1;

    function automatic logic [31:0] crc32_word(input logic [31:0] crc_in,
                                               input logic [31:0] d);
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 32; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
            else             c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/pkt_crc32.sv
module pkt_crc32
    import pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        feed,
    input  logic [31:0] word,
    output logic [31:0] crc_out
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc_q <= CRC_INIT;
        else if (feed)       acc_q <= crc32_word(acc_q, word);
    end

    assign crc_out = ~acc_q;
endmodule

// File: rtl/pkt_mask_walker.sv
module pkt_mask_walker #(
    parameter int NCH  = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NCH-1:0]  load_mask,
    input  logic            advance,
    output logic [CH_W-1:0] cur_ch,
    output logic            empty,
    output logic            last
);
    logic [NCH-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (load)    rem_q <= load_mask;
        else if (advance) rem_q <= rem_q & (rem_q - NCH'(1));
    end

    always_comb begin
        cur_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rem_q[i]) cur_ch = CH_W'(i);
        end
    end

    assign empty = (rem_q == '0);
    assign last  = !empty && ((rem_q & (rem_q - NCH'(1))) == '0);

    // R6 / R7: every step of the walk retires exactly one channel
    a_r6_walk_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !empty) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1));
endmodule

// File: rtl/evt_pkt_builder.sv
module evt_pkt_builder
    import pkt_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int SAMPLES = 60,
    parameter int AMP_W   = 18,
    parameter int TIME_W  = 12,
    parameter int QUAL_W  = 2,
    localparam int CH_W   = $clog2(NCH),
    localparam int IDX_W  = $clog2(SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [7:0]        pkt_id,
    input  logic [7:0]        trig_time,
    input  logic [15:0]       trig_tag,
    input  logic [NCH-1:0]    hit_mask,
    input  logic [NCH-1:0]    raw_mask,
    output logic [CH_W-1:0]   res_ch,
    input  logic [QUAL_W-1:0] res_qual,
    input  logic [TIME_W-1:0] res_time,
    input  logic [AMP_W-1:0]  res_amp,
    output logic [CH_W-1:0]   smp_ch,
    output logic [IDX_W-1:0]  smp_idx,
    input  logic [AMP_W-1:0]  smp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_last,
    output logic              busy
);
    pkt_state_e state_q, state_d;
    logic [2:0]       hdr_q;
    logic [IDX_W-1:0] smp_q;
    logic [7:0]       id_q, ttime_q;
    logic [15:0]      tag_q, len_q;
    logic [NCH-1:0]   hmask_q, rmask_q, eff_h, eff_r;
    logic [4:0]       nhit_q, nraw_q;
    logic             take, fire, smp_end;
    logic             h_empty, h_last, r_empty, r_last;
    logic [31:0]      crc_val;

    assign take    = start && (state_q == ST_IDLE);
    assign fire    = out_valid && out_ready;
    assign smp_end = (smp_q == IDX_W'(SAMPLES - 1));
    assign eff_h   = (mode == MODE_RAW) ? '0 : hit_mask;
    assign eff_r   = (mode == MODE_RES) ? '0 : raw_mask;

    pkt_mask_walker #(.NCH(NCH)) u_hit_walk (
        .clk(clk), .rst_n(rst_n), .load(take), .load_mask(eff_h),
        .advance(fire && state_q == ST_RES),
        .cur_ch(res_ch), .empty(h_empty), .last(h_last));

    pkt_mask_walker #(.NCH(NCH)) u_raw_walk (
        .clk(clk), .rst_n(rst_n), .load(take), .load_mask(eff_r),
        .advance(fire && state_q == ST_RAW && smp_end),
        .cur_ch(smp_ch), .empty(r_empty), .last(r_last));

    pkt_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(take),
        .feed(fire && state_q != ST_CRC), .word(out_data), .crc_out(crc_val));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HEAD;
            ST_HEAD: if (fire && hdr_q == 3'd5)
                         state_d = !h_empty ? ST_RES : (!r_empty ? ST_RAW : ST_CRC);
            ST_RES:  if (fire && h_last) state_d = !r_empty ? ST_RAW : ST_CRC;
            ST_RAW:  if (fire && smp_end && r_last) state_d = ST_CRC;
            ST_CRC:  if (fire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Counters and captured event fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0; smp_q <= '0; id_q <= '0; ttime_q <= '0; tag_q <= '0;
            len_q <= '0; hmask_q <= '0; rmask_q <= '0; nhit_q <= '0; nraw_q <= '0;
        end else if (take) begin
            hdr_q   <= '0;
            smp_q   <= '0;
            id_q    <= pkt_id;
            ttime_q <= trig_time;
            tag_q   <= trig_tag;
            hmask_q <= eff_h;
            rmask_q <= eff_r;
            nhit_q  <= 5'($countones(eff_h));
            nraw_q  <= 5'($countones(eff_r));
            len_q   <= 16'd5 + 16'($countones(eff_h))
                       + 16'(SAMPLES) * 16'($countones(eff_r));
        end else if (fire) begin
            if (state_q == ST_HEAD) hdr_q <= hdr_q + 3'd1;
            if (state_q == ST_RAW)  smp_q <= smp_end ? '0 : smp_q + IDX_W'(1);
        end
    end

    // Output logic
    always_comb begin
        out_data = '0;
        unique case (state_q)
            ST_IDLE: out_data = '0;
            ST_HEAD: begin
                unique case (hdr_q)
                    3'd0:    out_data = PKT_MAGIC;
                    3'd1:    out_data = {id_q, PKT_TYPE_TRG, len_q};
                    3'd3:    out_data = {3'b0, nraw_q, 1'b0, 7'(SAMPLES),
                                         3'b0, nhit_q, ttime_q};
                    3'd4:    out_data = {16'(hmask_q), tag_q};
                    3'd5:    out_data = {16'(rmask_q), 16'h0000};
                    default: out_data = '0;
                endcase
            end
            ST_RES:  out_data = 32'({res_qual, res_time, res_amp});
            ST_RAW:  out_data = 32'(smp_data);
            ST_CRC:  out_data = crc_val;
            default: out_data = '0;
        endcase
    end

    assign out_valid = (state_q != ST_IDLE);
    assign out_last  = (state_q == ST_CRC);
    assign busy      = (state_q != ST_IDLE);
    assign smp_idx   = smp_q;

    a_r2_magic_first: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_valid && out_data == PKT_MAGIC));
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
    a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(len_q) && $stable(hmask_q) && $stable(rmask_q)));
endmodule

// File: tb/tb_evt_pkt_builder.sv
module tb_evt_pkt_builder;
    logic        clk = 1'b0;
    logic        rst_n, start, out_ready, out_valid, out_last, busy;
    logic [1:0]  mode;
    logic [7:0]  pkt_id, trig_time;
    logic [15:0] trig_tag, hit_mask, raw_mask;
    logic [3:0]  res_ch, smp_ch;
    logic [5:0]  smp_idx;
    logic [1:0]  res_qual;
    logic [11:0] res_time;
    logic [17:0] res_amp, smp_data;
    logic [31:0] out_data;

    logic [1:0]  ev_q [16];
    logic [11:0] ev_t [16];
    logic [17:0] ev_a [16];
    int          salt;
    int          checks = 0;
    int          fails  = 0;
    logic [31:0] exp_w[$];

    always #10 clk = ~clk;

    evt_pkt_builder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pkt_id(pkt_id),
        .trig_time(trig_time), .trig_tag(trig_tag), .hit_mask(hit_mask),
        .raw_mask(raw_mask), .res_ch(res_ch), .res_qual(res_qual),
        .res_time(res_time), .res_amp(res_amp), .smp_ch(smp_ch),
        .smp_idx(smp_idx), .smp_data(smp_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .busy(busy));

    function automatic logic [17:0] smp_fn(int ch, int idx, int s);
        return 18'(ch * 9973 + idx * 257 + s * 31 + (idx << 11));
    endfunction

    function automatic logic [31:0] crc_ref(logic [31:0] c, logic [31:0] d);
        for (int b = 0; b < 32; b++) c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic string tag_of(int i, int nh, int last);
        if (i == 0)       return "R2";
        if (i == 1)       return "R3";
        if (i <= 3)       return "R4";
        if (i <= 5)       return "R5";
        if (i < 6 + nh)   return "R6";
        if (i < last)     return "R7";
        return "R9";
    endfunction

    assign res_qual = ev_q[res_ch];
    assign res_time = ev_t[res_ch];
    assign res_amp  = ev_a[res_ch];
    assign smp_data = smp_fn(int'(smp_ch), int'(smp_idx), salt);

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_pkt(logic [1:0] md, logic [15:0] hm, logic [15:0] rm,
                           logic [7:0] tt, bit inject, int rdy_pct);
        logic [15:0] eh, er;
        int nh, nr, n;
        bit done, injected, stalled;
        logic [31:0] c, prev;
        for (int i = 0; i < 16; i++) begin
            ev_q[i] = 2'($urandom); ev_t[i] = 12'($urandom); ev_a[i] = 18'($urandom);
        end
        salt = int'($urandom % 1000);
        eh = (md == 2'd1) ? 16'h0 : hm;
        er = (md == 2'd0) ? 16'h0 : rm;
        nh = $countones(eh); nr = $countones(er);
        exp_w.delete();
        exp_w.push_back(32'h5AA5FF00);
        exp_w.push_back({8'hA0 + 8'(nh), 8'd16, 16'(5 + nh + 60 * nr)});
        exp_w.push_back(32'h0);
        exp_w.push_back({3'b0, 5'(nr), 1'b0, 7'd60, 3'b0, 5'(nh), tt});
        exp_w.push_back({eh, 16'hC0DE ^ 16'(salt)});
        exp_w.push_back({er, 16'h0});
        for (int ch = 0; ch < 16; ch++)
            if (eh[ch]) exp_w.push_back({ev_q[ch], ev_t[ch], ev_a[ch]});
        for (int ch = 0; ch < 16; ch++)
            if (er[ch]) for (int k = 0; k < 60; k++) exp_w.push_back({14'b0, smp_fn(ch, k, salt)});
        c = 32'hFFFFFFFF;
        foreach (exp_w[k]) c = crc_ref(c, exp_w[k]);
        exp_w.push_back(~c);

        @(negedge clk);
        mode = md; hit_mask = hm; raw_mask = rm; trig_time = tt;
        pkt_id = 8'hA0 + 8'(nh); trig_tag = 16'hC0DE ^ 16'(salt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; done = 0; injected = 0; stalled = 0; prev = '0;
        while (!done) begin
            if (n != 0 || stalled) @(negedge clk);
            start = 1'b0;
            if (inject && !injected && n == 3) begin
                start = 1'b1; hit_mask = 16'($urandom); raw_mask = 16'($urandom);
                mode = 2'd2; injected = 1;
            end
            out_ready = (int'($urandom % 100) < rdy_pct);
            #1;
            if (stalled) check(out_valid && out_data == prev, "R10", out_data, prev);
            if (out_valid && out_ready) begin
                if (n < exp_w.size())
                    check(out_data == exp_w[n], tag_of(n, nh, exp_w.size() - 1), out_data, exp_w[n]);
                else
                    check(0, "R8", 32'(n), 32'(exp_w.size()));
                if (out_last) begin
                    check(n == exp_w.size() - 1, "R9", 32'(n), 32'(exp_w.size() - 1));
                    done = 1;
                end
                n++;
            end
            stalled = out_valid && !out_ready;
            prev = out_data;
        end
        check(n == exp_w.size(), "R8", 32'(n), 32'(exp_w.size()));
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            check(!out_valid && !busy, "R11", {31'b0, out_valid}, 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 0; start = 0; out_ready = 0; mode = 0; pkt_id = 0; trig_time = 0;
        trig_tag = 0; hit_mask = 0; raw_mask = 0; salt = 0;
        for (int i = 0; i < 16; i++) begin ev_q[i] = 0; ev_t[i] = 0; ev_a[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(!out_valid && !busy, "R1", {30'b0, out_valid, busy}, 32'h0);
        // directed corners
        run_pkt(2'd2, 16'h0000, 16'h0000, 8'd0,   0, 100);  // empty packet, length 5
        run_pkt(2'd2, 16'hFFFF, 16'hFFFF, 8'd143, 0, 75);   // full packet, length 981
        run_pkt(2'd0, 16'h00C0, 16'h0400, 8'd14,  0, 70);   // R8 results only, raw mask dropped
        run_pkt(2'd1, 16'hFFFF, 16'h8001, 8'd77,  0, 70);   // R8 raw only, hit mask dropped
        run_pkt(2'd3, 16'h8001, 16'h0001, 8'd5,   1, 60);   // R11 start while busy
        for (int e = 0; e < 25; e++)
            run_pkt(2'($urandom), 16'($urandom), 16'($urandom) & 16'h0111,
                    8'($urandom % 144), (e % 4) == 0, 50 + int'($urandom % 50));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule